// File: doc/BRIEF.md
# Cascaded Secondary Interrupt Controller

This block collects up to 32 peripheral interrupt lines and presents them to a parent interrupt controller as a single interrupt request. Each line is brought into the clock domain by a two-stage synchroniser. It is then qualified by two per-line settings. A mode bit picks edge or level sensitivity. A sense bit picks high/rising or low/falling. Edge events are held in a per-line latch until software acknowledges them. A level line is pending for as long as its input stays active.

Software reaches the block through a single-cycle register port. A write is taken on the clock edge. Read data is combinational from the address. The enable mask changes only through separate set and clear addresses, so no read-modify-write is needed, and the mask can still be read back. The status view is the pending set masked by enable. The parent output is raised when any status bit is set. Alongside it, the block reports the lowest-numbered pending source and a valid flag, so the parent's handler can dispatch without scanning the status word.

Register word addresses on `addr_i`: 0 enable mask (read only), 1 enable-set (write only), 2 enable-clear (write only), 3 mode (read/write), 4 sense (read/write), 5 acknowledge (write only), 6 status (read only). Reads of write-only addresses and of address 7 return zero. Bit n of every register belongs to source n.

Top module: `sirc_ctrl`

## Requirements
- R1: A write to address 1 sets every enable bit whose data bit is 1 and leaves enable bits written as 0 unchanged.
- R2: A write to address 2 clears every enable bit whose data bit is 1 and leaves the others unchanged. The enable mask reads back at address 0.
- R3: Mode bit 1 makes a source edge-triggered and mode bit 0 makes it level-sensitive. The mode register reads back what was written.
- R4: Sense bit 1 selects active-low level or falling-edge detection, and sense bit 0 selects active-high level or rising-edge detection. The sense register reads back what was written.
- R5: Each input passes through two flops. A level change shows in status after the second clock edge. An edge shows in status after the third clock edge.
- R6: An edge source latches pending on its selected transition even while disabled. Status at address 6 is pending AND enable, so the latched event appears once it is enabled.
- R7: Writing 1 to a bit at address 5 removes that edge source's latched pending state. Bits written 0 leave pending unchanged.
- R8: A level source's pending follows its synchronised input after sense is applied. An acknowledge has no effect on it while the input stays active.
- R9: `irq_o` is high exactly when at least one status bit is set.
- R10: `pend_idx_o` gives the lowest-numbered set status bit, and `pend_vld_o` is high whenever any status bit is set. With no status bit set, the index is 0 and the flag is low.
- R11: When an acknowledge of an edge source is written in the same cycle as a new edge on it, the new edge wins and pending stays set.
- R12: After reset, enable, mode, sense and all pending latches are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Raw peripheral interrupt lines |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` |
| irq_o | output | 1 | Cascade request to the parent controller |
| pend_idx_o | output | $clog2(N_SRC) | Lowest pending enabled source |
| pend_vld_o | output | 1 | Index valid |

## Verification
A software acknowledge and a fresh edge detection can land on the same source's pending latch in the same cycle. The bench provokes this on one edge source. It first leaves an older event pending. It then raises the input again and times the acknowledge write so that it reaches the clock edge at which the synchronised edge is first seen. Status must still show the source after that edge. A later acknowledge with no edge must clear it, which shows that the first acknowledge lost only because of the collision.

// File: rtl/sirc_pkg.sv
package sirc_pkg;
  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_EN     = 3'd0,
    A_EN_SET = 3'd1,
    A_EN_CLR = 3'd2,
    A_MODE   = 3'd3,
    A_SENSE  = 3'd4,
    A_ACK    = 3'd5,
    A_STAT   = 3'd6,
    A_RSVD   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/sirc_sync.sv
module sirc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sirc_detect.sv
module sirc_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sync_i,
  input  logic [N-1:0] mode_i,   // 1 edge, 0 level
  input  logic [N-1:0] sense_i,  // 1 low/falling, 0 high/rising
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    logic prev_q, pend_q, hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sync_i[g];
    end

    assign hit = sense_i[g] ? (prev_q & ~sync_i[g]) : (~prev_q & sync_i[g]);

    // new edge beats a same-cycle acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= mode_i[g] & (hit | (pend_q & ~ack_i[g]));
    end

    assign pend_o[g] = mode_i[g] ? pend_q : (sync_i[g] ^ sense_i[g]);

    assert_edge_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[g] && hit && ack_i[g]) |=> pend_o[g] || !mode_i[g]);

    assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[g] && !hit && ack_i[g]) |=> !pend_q);

    assert_latch_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[g] && pend_q && !ack_i[g]) |=> pend_q || !$past(mode_i[g]) || !mode_i[g]);
  end
endmodule

// File: rtl/sirc_regs.sv
module sirc_regs
  import sirc_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N-1:0]      status_i,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      sense_o,
  output logic [N-1:0]      ack_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0] en_q, mode_q, sense_q, wd;
  logic         wr;
  reg_addr_e    ra;

  assign wd = wdata_i[N-1:0];
  assign wr = req_i & we_i;
  assign ra = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      mode_q  <= '0;
      sense_q <= '0;
    end else if (wr) begin
      unique case (ra)
        A_EN_SET: en_q    <= en_q | wd;
        A_EN_CLR: en_q    <= en_q & ~wd;
        A_MODE:   mode_q  <= wd;
        A_SENSE:  sense_q <= wd;
        default: ;
      endcase
    end
  end

  assign ack_o = (wr && ra == A_ACK) ? wd : '0;

  always_comb begin
    rdata_o = '0;
    unique case (ra)
      A_EN:    rdata_o[N-1:0] = en_q;
      A_MODE:  rdata_o[N-1:0] = mode_q;
      A_SENSE: rdata_o[N-1:0] = sense_q;
      A_STAT:  rdata_o[N-1:0] = status_i;
      default: ;
    endcase
  end

  assign en_o    = en_q;
  assign mode_o  = mode_q;
  assign sense_o = sense_q;

  assert_en_set_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ra == A_EN_SET) |=> ((en_q & $past(wd)) == $past(wd)) &&
                               ((en_q & ~$past(wd)) == ($past(en_q) & ~$past(wd))));

  assert_en_clr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && ra == A_EN_CLR) |=> ((en_q & $past(wd)) == '0) &&
                               ((en_q & ~$past(wd)) == ($past(en_q) & ~$past(wd))));

  assert_en_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (ra == A_EN_SET || ra == A_EN_CLR)) |=> $stable(en_q));
endmodule

// File: rtl/sirc_prio.sv
module sirc_prio #(
  parameter int unsigned N     = 32,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     status_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  // descending scan: last hit is the lowest index
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (status_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign vld_o = |status_i;

  always_comb begin
    if (vld_o) begin
      assert_lowest_R10: assert (status_i[idx_o] &&
        ((status_i & ((N'(1) << idx_o) - N'(1))) == '0));
    end
  end
endmodule

// File: rtl/sirc_ctrl.sv
module sirc_ctrl
  import sirc_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              pend_vld_o
);
  logic [N_SRC-1:0] sync, en, mode, sense, ack, pend, status;

  sirc_sync #(.W(N_SRC)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (src_i), .q_o (sync)
  );

  sirc_regs #(.N(N_SRC), .DATA_W(DATA_W)) u_regs (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .we_i (we_i),
    .addr_i (addr_i), .wdata_i (wdata_i), .status_i (status),
    .en_o (en), .mode_o (mode), .sense_o (sense), .ack_o (ack),
    .rdata_o (rdata_o)
  );

  sirc_detect #(.N(N_SRC)) u_det (
    .clk_i (clk_i), .rst_ni (rst_ni), .sync_i (sync), .mode_i (mode),
    .sense_i (sense), .ack_i (ack), .pend_o (pend)
  );

  assign status = pend & en;
  assign irq_o  = |status;

  sirc_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
    .status_i (status), .idx_o (pend_idx_o), .vld_o (pend_vld_o)
  );

  assert_irq_vld_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == pend_vld_o);

  assert_masked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
endmodule

// File: tb/sirc_ctrl_test.sv
`timescale 1ns/1ps
module sirc_ctrl_test;
  localparam logic [2:0] EN = 3'd0, ESET = 3'd1, ECLR = 3'd2, MODE = 3'd3,
                         SENSE = 3'd4, ACK = 3'd5, STAT = 3'd6;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] en;
    logic [4:0]  idx;
    logic        vld;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 5'd0,  1'b0},
    '{32'h8000_0000, 32'hFFFF_FFFF, 5'd31, 1'b1},
    '{32'h0000_0110, 32'hFFFF_FFFF, 5'd4,  1'b1},
    '{32'h0000_0110, 32'hFFFF_FFEF, 5'd8,  1'b1},
    '{32'hFFFF_FFFF, 32'h0000_0000, 5'd0,  1'b0},
    '{32'h0000_0001, 32'hFFFF_FFFF, 5'd0,  1'b1},
    '{32'h0040_0400, 32'h0040_0000, 5'd22, 1'b1}
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic [31:0] src = '0, wdata = '0, rdata;
  logic        req = 1'b0, we = 1'b0, irq, vld;
  logic [2:0]  addr = '0;
  logic [4:0]  idx;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sirc_ctrl uut (
    .clk_i (clk), .rst_ni (rst_ni), .src_i (src), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq),
    .pend_idx_o (idx), .pend_vld_o (vld)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; req = 1'b1; we = 1'b1;
    tick();
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; req = 1'b1; we = 1'b0;
    #0.5 d = rdata;
    req = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] st;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R12 reset state
    chk_reg("R12 enable", EN, 32'h0);
    chk_reg("R12 mode", MODE, 32'h0);
    chk_reg("R12 sense", SENSE, 32'h0);
    chk_reg("R12 status", STAT, 32'h0);
    chk("R12 irq", {31'h0, irq}, 32'h0);

    // R1 / R2 set and clear
    wr(ESET, 32'h0000_00F0); chk_reg("R1 set", EN, 32'h0000_00F0);
    wr(ESET, 32'h0000_0003); chk_reg("R1 zeros keep", EN, 32'h0000_00F3);
    wr(ECLR, 32'h0000_0030); chk_reg("R2 clear", EN, 32'h0000_00C3);
    wr(ECLR, 32'hFFFF_FFFF); chk_reg("R2 clear all", EN, 32'h0);

    // R3 / R4 read back
    wr(MODE, 32'hA5A5_0F0F);  chk_reg("R3 mode rw", MODE, 32'hA5A5_0F0F);
    wr(SENSE, 32'h1234_5678); chk_reg("R4 sense rw", SENSE, 32'h1234_5678);
    wr(MODE, 32'h0); wr(SENSE, 32'h0);

    // R9 / R10 vector walk, all level active-high
    foreach (VECS[i]) begin
      wr(ECLR, 32'hFFFF_FFFF);
      wr(ESET, VECS[i].en);
      src = VECS[i].src;
      tick(); tick();
      chk_reg("R10 status", STAT, VECS[i].src & VECS[i].en);
      chk("R9 irq", {31'h0, irq}, {31'h0, VECS[i].vld});
      chk("R10 vld", {31'h0, vld}, {31'h0, VECS[i].vld});
      chk("R10 idx", {27'h0, idx}, {27'h0, VECS[i].idx});
      src = '0; tick(); tick();
    end

    // R5 level latency
    wr(ESET, 32'hFFFF_FFFF);
    src[3] = 1'b1;
    tick(); chk("R5 level one edge", {31'h0, irq}, 32'h0);
    tick(); chk("R5 level two edges", {31'h0, irq}, 32'h1);
    src[3] = 1'b0; tick(); tick();

    // R4 active-low level
    wr(ECLR, 32'hFFFF_FFFF); wr(ESET, 32'h20);
    wr(SENSE, 32'h20);
    chk_reg("R4 low level", STAT, 32'h20);
    src[5] = 1'b1; tick(); tick();
    chk_reg("R4 low released", STAT, 32'h0);
    src[5] = 1'b0; wr(SENSE, 32'h0); tick(); tick();

    // R6 latch while disabled, R7 acknowledge
    wr(ECLR, 32'hFFFF_FFFF);
    wr(MODE, 32'h80);
    src[7] = 1'b1; tick(); tick(); tick();
    chk_reg("R6 disabled hidden", STAT, 32'h0);
    chk("R6 disabled irq", {31'h0, irq}, 32'h0);
    wr(ESET, 32'h80);
    chk_reg("R6 latched shows", STAT, 32'h80);
    src[7] = 1'b0; tick(); tick(); tick();
    chk_reg("R3 edge held", STAT, 32'h80);
    wr(ACK, 32'h7F); chk_reg("R7 zero bit keeps", STAT, 32'h80);
    wr(ACK, 32'h80); chk_reg("R7 ack clears", STAT, 32'h0);

    // R5 edge latency
    src[7] = 1'b1;
    tick(); tick(); chk_reg("R5 edge two edges", STAT, 32'h0);
    tick();         chk_reg("R5 edge three edges", STAT, 32'h80);
    wr(ACK, 32'h80);
    src[7] = 1'b0; tick(); tick(); tick();
    chk_reg("R5 edge clean", STAT, 32'h0);

    // R4 falling edge
    wr(MODE, 32'h280); wr(SENSE, 32'h200); wr(ESET, 32'h200);
    src[9] = 1'b1; tick(); tick(); tick();
    chk_reg("R4 rise ignored", STAT, 32'h0);
    src[9] = 1'b0; tick(); tick(); tick();
    chk_reg("R4 fall caught", STAT, 32'h200);
    chk("R10 idx fall", {27'h0, idx}, 32'd9);
    wr(ACK, 32'h200);
    chk_reg("R7 fall acked", STAT, 32'h0);

    // R8 level ignores acknowledge
    wr(ESET, 32'h1000);
    src[12] = 1'b1; tick(); tick();
    chk_reg("R8 level active", STAT, 32'h1000);
    wr(ACK, 32'h1000);
    chk_reg("R8 ack no effect", STAT, 32'h1000);
    tick(); chk_reg("R8 still pending", STAT, 32'h1000);
    src[12] = 1'b0; tick(); tick();
    chk_reg("R8 follows input", STAT, 32'h0);

    // R11 acknowledge collides with new edge
    src[7] = 1'b1; tick(); tick(); tick();
    chk_reg("R11 first event", STAT, 32'h80);
    src[7] = 1'b0; tick(); tick(); tick();
    src[7] = 1'b1; tick(); tick();
    wr(ACK, 32'h80);
    chk_reg("R11 edge wins", STAT, 32'h80);
    tick(); chk_reg("R11 held", STAT, 32'h80);
    wr(ACK, 32'h80);
    chk_reg("R11 later ack clears", STAT, 32'h0);
    chk("R9 idle irq", {31'h0, irq}, 32'h0);

    // R2 enable reads back at its own address
    chk_reg("R2 enable readback", EN, 32'h0000_1280);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule